// File: doc/BRIEF.md
# HDR-DDR Transfer Launch Sequencer

This block sits between a command queue and a bus engine of a two-wire controller that supports a double-data-rate high-rate mode. It takes one decoded transfer command at a time and decides when the transfer may go out on the bus. It then emits the framing steps for that transfer as single-cycle pulses: bus START, the CCC that enters the double-data-rate mode, the mode command word, one pulse per data word, in-mode restart, in-mode exit and bus STOP. The bit-level protocol, the parity and preamble generation and the data FIFOs all live elsewhere. The FIFOs are seen here only as a live transmit fill level and a live receive free-space count.

A transfer that opens the bus with START is held back until its direction's FIFO meets a programmable start threshold. A command that follows a transfer which left the bus in the high-rate mode (its "last" flag was 0) normally continues with an in-mode restart. If its threshold is not met at that moment, the sequencer closes the bus with exit and STOP instead, waits for the threshold, and relaunches with START. If the FIFO runs dry (write) or full (read) in the middle of a transfer, the transfer is terminated rather than stalled. Every command ends with exactly one completion pulse that carries an error code.

Top module: `hdr_launch_seq`

## Requirements
- R1: After reset, `busy`, `done` and every bus step pulse are 0.
- R2: With no open high-rate session and the start threshold met, `bus_start` rises one cycle after the command is accepted. It is followed in consecutive cycles by `bus_enthdr`, then `bus_hdr_cmd`, then the data word pulses. At most one step pulse or `done` is high in any cycle.
- R3: While `bus_hdr_cmd` is high, `hdr_cmd_byte` equals {cmd_rnw, cmd_code[6:0]}, so read codes fall in 0x80–0xFF and write codes in 0x00–0x7F. `hdr_dev_idx` equals the accepted device index.
- R4: A transfer that opens with START issues no step pulse until `tx_level >= tx_thresh` (write, cmd_rnw=0) or `rx_free >= rx_thresh` (read, cmd_rnw=1).
- R5: When the previous transfer ended with cmd_last=0 and the new command's threshold is met, the new transfer begins with `bus_hdr_restart` one cycle after acceptance, then `bus_hdr_cmd`, with no START or enter-CCC.
- R6: When the previous transfer ended with cmd_last=0 and the new command's threshold is not met, the sequencer emits `bus_hdr_exit` then `bus_stop`. It then waits for the threshold and runs the full START sequence.
- R7: With cmd_last=1, the last step of a transfer is `bus_hdr_exit` followed by `bus_stop` in the next cycle. With cmd_last=0, no closing step is emitted and the session stays open.
- R8: A transfer that completes normally emits exactly cmd_len word pulses. With cmd_len=0, the command step is followed directly by the closing steps or by completion.
- R9: A word pulse is issued only while the direction's FIFO level exceeds the number of words already in flight. On starvation the transfer ends with exit and STOP, and `done_err` is 3 for write underflow or 4 for read overflow.
- R10: A command with cmd_speed != 6 completes with `done_err` = 1. A command with cmd_speed = 6 and cmd_short = 1 completes with `done_err` = 2. In both cases `done` comes one cycle after acceptance and no bus step is emitted.
- R11: Each accepted command yields exactly one `done` pulse, with `done_err` = 0 on success. `busy` is high from acceptance through the `done` cycle and low in the cycle after.
- R12: `cmd_valid` while `busy` is high is ignored: no extra completion, and no change to the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_code | input | 7 | Low seven bits of the mode command code |
| cmd_rnw | input | 1 | 1 = read, 0 = write; top bit of the command code |
| cmd_dev_idx | input | IDX_W | Device table index |
| cmd_speed | input | 3 | Speed field; 6 selects double-data-rate mode |
| cmd_short | input | 1 | Short-data command format flag |
| cmd_len | input | LEN_W | Number of data words |
| cmd_last | input | 1 | 1 = close the bus after this transfer |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_free | input | LVL_W | Receive FIFO free entries |
| tx_thresh | input | LVL_W | Write start threshold |
| rx_thresh | input | LVL_W | Read start threshold |
| busy | output | 1 | A command is in progress |
| bus_start | output | 1 | Issue bus START |
| bus_enthdr | output | 1 | Issue the mode-entry CCC |
| bus_hdr_cmd | output | 1 | Issue the mode command word |
| bus_word | output | 1 | Move one data word |
| bus_hdr_restart | output | 1 | Issue in-mode restart |
| bus_hdr_exit | output | 1 | Issue in-mode exit pattern |
| bus_stop | output | 1 | Issue bus STOP |
| hdr_cmd_byte | output | 8 | Command code for the command step |
| hdr_dev_idx | output | IDX_W | Device index for the command step |
| done | output | 1 | Single-cycle completion pulse |
| done_err | output | 3 | Completion code, valid with `done` |

## Verification
Every step pulse is registered from the next-state decision, so the first step (START, restart, exit, or `done` for a rejected command) appears exactly one cycle after the accepting edge. Each following step appears one cycle after the one before, with one cycle per data word. The bench time-stamps every pulse 1 ns after the clock edge and checks the first stamp against the acceptance cycle plus one. It then compares the whole ordered step string of each command with an expected string. The FIFO model in the bench retires a word one edge after its pulse, which matches the in-flight allowance of R9.

// File: rtl/hdr_seq_pkg.sv
`timescale 1ns/1ps
package hdr_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_THWAIT, ST_START, ST_ENTHDR, ST_RSTRT,
    ST_HCMD, ST_DATA, ST_EXIT, ST_STOP, ST_FIN
  } seq_state_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_MODE      = 3'd1,
    ERR_FORMAT    = 3'd2,
    ERR_UNDERFLOW = 3'd3,
    ERR_OVERFLOW  = 3'd4
  } seq_err_e;

  localparam logic [2:0] SPEED_DDR = 3'd6;
endpackage

// File: rtl/hdr_cmd_decode.sv
`timescale 1ns/1ps
module hdr_cmd_decode
  import hdr_seq_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic [2:0]      speed,
  input  logic            short_fmt,
  input  logic [CODE_W-1:0] code,
  input  logic            rnw,
  output seq_err_e        err,
  output logic [CODE_W:0] code_byte
);
  // direction bit forms the top of the command code
  assign code_byte = {rnw, code};

  always_comb begin
    if (speed != SPEED_DDR)  err = ERR_MODE;
    else if (short_fmt)      err = ERR_FORMAT;
    else                     err = ERR_NONE;
  end
endmodule

// File: rtl/hdr_fifo_gate.sv
`timescale 1ns/1ps
module hdr_fifo_gate #(
  parameter int LVL_W = 8
) (
  input  logic             rnw,
  input  logic             in_flight,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_free,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             th_ok,
  output logic             avail
);
  logic [LVL_W-1:0] need;
  assign need  = {{(LVL_W-1){1'b0}}, in_flight};
  assign th_ok = rnw ? (rx_free >= rx_thresh) : (tx_level >= tx_thresh);
  // a word already on its way still counts in the level until the next edge
  assign avail = rnw ? (rx_free > need) : (tx_level > need);
endmodule

// File: rtl/hdr_word_ctr.sv
`timescale 1ns/1ps
module hdr_word_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] remaining,
  output logic             last_one
);
  always_ff @(posedge clk) begin
    if (rst)       remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec && remaining != '0) remaining <= remaining - 1'b1;
  end

  assign last_one = (remaining == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/hdr_launch_seq.sv
`timescale 1ns/1ps
module hdr_launch_seq
  import hdr_seq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 16,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [6:0]       cmd_code,
  input  logic             cmd_rnw,
  input  logic [IDX_W-1:0] cmd_dev_idx,
  input  logic [2:0]       cmd_speed,
  input  logic             cmd_short,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_last,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_free,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             busy,
  output logic             bus_start,
  output logic             bus_enthdr,
  output logic             bus_hdr_cmd,
  output logic             bus_word,
  output logic             bus_hdr_restart,
  output logic             bus_hdr_exit,
  output logic             bus_stop,
  output logic [7:0]       hdr_cmd_byte,
  output logic [IDX_W-1:0] hdr_dev_idx,
  output logic             done,
  output logic [2:0]       done_err
);
  localparam int CODE_W = 7;

  seq_state_e state, nxt;
  seq_err_e   err_q, dec_err;
  logic [CODE_W:0]  dec_byte;
  logic [LEN_W-1:0] len_q, remaining;
  logic rnw_q, last_q, in_hdr_q, relaunch_q;
  logic accept, sel_rnw, th_ok, avail, cnt_last, starve;

  assign busy    = (state != ST_IDLE);
  assign accept  = cmd_valid && (state == ST_IDLE);
  assign sel_rnw = (state == ST_IDLE) ? cmd_rnw : rnw_q;

  hdr_cmd_decode #(.CODE_W(CODE_W)) u_dec (
    .speed(cmd_speed), .short_fmt(cmd_short), .code(cmd_code),
    .rnw(cmd_rnw), .err(dec_err), .code_byte(dec_byte)
  );

  hdr_fifo_gate #(.LVL_W(LVL_W)) u_gate (
    .rnw(sel_rnw), .in_flight(state == ST_DATA),
    .tx_level(tx_level), .rx_free(rx_free),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .th_ok(th_ok), .avail(avail)
  );

  hdr_word_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .load(accept), .load_val(cmd_len),
    .dec(state == ST_DATA), .remaining(remaining), .last_one(cnt_last)
  );

  assign starve = ((state == ST_HCMD) && (len_q != '0) && !avail) ||
                  ((state == ST_DATA) && !cnt_last && !avail);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        if (dec_err != ERR_NONE) nxt = ST_FIN;
        else if (in_hdr_q)       nxt = th_ok ? ST_RSTRT : ST_EXIT;
        else                     nxt = th_ok ? ST_START : ST_THWAIT;
      end
      ST_THWAIT: if (th_ok) nxt = ST_START;
      ST_START:  nxt = ST_ENTHDR;
      ST_ENTHDR: nxt = ST_HCMD;
      ST_RSTRT:  nxt = ST_HCMD;
      ST_HCMD: begin
        if (len_q == '0) nxt = last_q ? ST_EXIT : ST_FIN;
        else             nxt = avail ? ST_DATA : ST_EXIT;
      end
      ST_DATA: begin
        if (cnt_last) nxt = last_q ? ST_EXIT : ST_FIN;
        else          nxt = avail ? ST_DATA : ST_EXIT;
      end
      ST_EXIT: nxt = ST_STOP;
      ST_STOP: nxt = relaunch_q ? ST_THWAIT : ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      err_q <= ERR_NONE;
      {rnw_q, last_q, in_hdr_q, relaunch_q} <= '0;
      len_q <= '0;
      {bus_start, bus_enthdr, bus_hdr_cmd, bus_word} <= '0;
      {bus_hdr_restart, bus_hdr_exit, bus_stop, done} <= '0;
      done_err     <= '0;
      hdr_cmd_byte <= '0;
      hdr_dev_idx  <= '0;
    end else begin
      state           <= nxt;
      bus_start       <= (nxt == ST_START);
      bus_enthdr      <= (nxt == ST_ENTHDR);
      bus_hdr_cmd     <= (nxt == ST_HCMD);
      bus_word        <= (nxt == ST_DATA);
      bus_hdr_restart <= (nxt == ST_RSTRT);
      bus_hdr_exit    <= (nxt == ST_EXIT);
      bus_stop        <= (nxt == ST_STOP);
      done            <= (nxt == ST_FIN);
      done_err        <= (nxt == ST_FIN) ? (accept ? dec_err : err_q) : ERR_NONE;
      if (accept) begin
        rnw_q        <= cmd_rnw;
        last_q       <= cmd_last;
        len_q        <= cmd_len;
        err_q        <= dec_err;
        hdr_cmd_byte <= dec_byte;
        hdr_dev_idx  <= cmd_dev_idx;
      end else if (starve) begin
        err_q <= rnw_q ? ERR_OVERFLOW : ERR_UNDERFLOW;
      end
      if (accept && dec_err == ERR_NONE && in_hdr_q && !th_ok) relaunch_q <= 1'b1;
      else if (state == ST_THWAIT && th_ok)                   relaunch_q <= 1'b0;
      if (nxt == ST_EXIT) in_hdr_q <= 1'b0;
      else if ((state == ST_HCMD || state == ST_DATA) && nxt == ST_FIN) in_hdr_q <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  logic [LEN_W-1:0] words_seen;
  always_ff @(posedge clk) begin
    if (rst || accept) words_seen <= '0;
    else if (bus_word) words_seen <= words_seen + 1'b1;
  end

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_start, bus_enthdr, bus_hdr_cmd, bus_word,
              bus_hdr_restart, bus_hdr_exit, bus_stop, done}));
  a_r2_start_then_enter: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> bus_enthdr);
  a_r2_enter_then_cmd: assert property (@(posedge clk) disable iff (rst)
    bus_enthdr |=> bus_hdr_cmd);
  a_r5_restart_then_cmd: assert property (@(posedge clk) disable iff (rst)
    bus_hdr_restart |=> bus_hdr_cmd);
  a_r7_exit_then_stop: assert property (@(posedge clk) disable iff (rst)
    bus_hdr_exit |=> bus_stop);
  a_r4_tx_thresh_met: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !rnw_q) |-> ($past(tx_level) >= $past(tx_thresh)));
  a_r4_rx_thresh_met: assert property (@(posedge clk) disable iff (rst)
    (bus_start && rnw_q) |-> ($past(rx_free) >= $past(rx_thresh)));
  a_r9_tx_not_empty: assert property (@(posedge clk) disable iff (rst)
    (bus_word && !rnw_q) |-> (tx_level != '0));
  a_r9_rx_not_full: assert property (@(posedge clk) disable iff (rst)
    (bus_word && rnw_q) |-> (rx_free != '0));
  a_r8_word_count: assert property (@(posedge clk) disable iff (rst)
    (done && done_err == 3'd0) |-> (words_seen == len_q));
  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && (done_err == 3'd1 || done_err == 3'd2)) |-> !$past(busy));
  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: tb/hdr_launch_seq_tb_top.sv
`timescale 1ns/1ps
module hdr_launch_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic cmd_valid = 0, cmd_rnw = 0, cmd_short = 0, cmd_last = 0;
  logic [6:0]  cmd_code = '0;
  logic [4:0]  cmd_dev_idx = '0;
  logic [2:0]  cmd_speed = 3'd6;
  logic [15:0] cmd_len = '0;
  logic [7:0]  tx_thresh = 8'd4, rx_thresh = 8'd4;
  logic [7:0]  tx_base = 0, rx_base = 0, tx_pops = 0, rx_pops = 0;
  logic [7:0]  tx_level, rx_free;
  assign tx_level = tx_base - tx_pops;
  assign rx_free  = rx_base - rx_pops;

  logic busy, bus_start, bus_enthdr, bus_hdr_cmd, bus_word;
  logic bus_hdr_restart, bus_hdr_exit, bus_stop, done;
  logic [7:0] hdr_cmd_byte;
  logic [4:0] hdr_dev_idx;
  logic [2:0] done_err;

  hdr_launch_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_rnw(cmd_rnw), .cmd_dev_idx(cmd_dev_idx), .cmd_speed(cmd_speed),
    .cmd_short(cmd_short), .cmd_len(cmd_len), .cmd_last(cmd_last),
    .tx_level(tx_level), .rx_free(rx_free), .tx_thresh(tx_thresh),
    .rx_thresh(rx_thresh), .busy(busy), .bus_start(bus_start),
    .bus_enthdr(bus_enthdr), .bus_hdr_cmd(bus_hdr_cmd), .bus_word(bus_word),
    .bus_hdr_restart(bus_hdr_restart), .bus_hdr_exit(bus_hdr_exit),
    .bus_stop(bus_stop), .hdr_cmd_byte(hdr_cmd_byte),
    .hdr_dev_idx(hdr_dev_idx), .done(done), .done_err(done_err)
  );

  int checks = 0, fails = 0, cyc = 0, done_n = 0, acc = 0, mark = 0, dmark = 0;
  int ev_cyc[1024];
  string trs = "";
  logic cur_rd = 0, pend_tx = 0, pend_rx = 0;
  logic [7:0] cap_byte = 0;
  logic [4:0] cap_idx = 0;
  logic [2:0] cap_err = 0;

  // monitor: samples 1 ns after each edge; FIFO pops land one edge after the word
  always @(posedge clk) begin
    #1;
    cyc++;
    if (pend_tx) tx_pops++;
    if (pend_rx) rx_pops++;
    pend_tx = bus_word && !cur_rd;
    pend_rx = bus_word && cur_rd;
    if (trs.len() < 1000) begin
      if (bus_start)       begin ev_cyc[trs.len()] = cyc; trs = {trs, "S"}; end
      if (bus_enthdr)      begin ev_cyc[trs.len()] = cyc; trs = {trs, "E"}; end
      if (bus_hdr_cmd)     begin ev_cyc[trs.len()] = cyc; trs = {trs, "C"};
                                 cap_byte = hdr_cmd_byte; cap_idx = hdr_dev_idx; end
      if (bus_word)        begin ev_cyc[trs.len()] = cyc; trs = {trs, "W"}; end
      if (bus_hdr_restart) begin ev_cyc[trs.len()] = cyc; trs = {trs, "R"}; end
      if (bus_hdr_exit)    begin ev_cyc[trs.len()] = cyc; trs = {trs, "X"}; end
      if (bus_stop)        begin ev_cyc[trs.len()] = cyc; trs = {trs, "P"}; end
      if (done)            begin ev_cyc[trs.len()] = cyc; trs = {trs, "D"};
                                 cap_err = done_err; done_n++; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  function automatic string seg();
    if (trs.len() > mark) return trs.substr(mark, trs.len() - 1);
    return "";
  endfunction

  task automatic chk_seq(input string req, input string exp);
    string a = seg();
    chk(a == exp, req, "step order", a, exp);
  endtask

  task automatic chk_first(input string req);
    int got = (trs.len() > mark) ? ev_cyc[mark] - acc : -1;
    chk(got == 1, req, "first step latency", $sformatf("%0d", got), "1");
  endtask

  task automatic set_tx(input int n); tx_base = 8'(n) + tx_pops; endtask
  task automatic set_rx(input int n); rx_base = 8'(n) + rx_pops; endtask

  task automatic issue(input logic [6:0] code, input logic rnw, input logic [2:0] spd,
                       input logic sh, input int len, input logic last, input logic [4:0] idx);
    @(negedge clk);
    cmd_code = code; cmd_rnw = rnw; cmd_speed = spd; cmd_short = sh;
    cmd_len = 16'(len); cmd_last = last; cmd_dev_idx = idx; cmd_valid = 1'b1;
    cur_rd = rnw; acc = cyc; mark = trs.len(); dmark = done_n;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (done_n == dmark && k < 400) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R1", "busy/done after reset",
        $sformatf("%b%b", busy, done), "00");
    chk({bus_start, bus_enthdr, bus_hdr_cmd, bus_word, bus_hdr_restart,
         bus_hdr_exit, bus_stop} == '0, "R1", "pulses after reset", "nonzero", "0");
  endtask

  task automatic t_write_cold();
    set_tx(8);
    issue(7'h15, 0, 3'd6, 0, 3, 1, 5'd5);
    wait_done();
    chk_seq("R2 R7 R8", "SECWWWXPD");
    chk_first("R2");
    chk(cap_byte == 8'h15 && cap_idx == 5'd5, "R3", "write code/index",
        $sformatf("%h/%0d", cap_byte, cap_idx), "15/5");
    chk(cap_err == 0 && done_n - dmark == 1, "R11", "one clean done",
        $sformatf("err%0d n%0d", cap_err, done_n - dmark), "err0 n1");
    chk(busy == 0, "R11", "busy after done", $sformatf("%b", busy), "0");
  endtask

  task automatic t_chain();
    set_rx(8);
    issue(7'h20, 1, 3'd6, 0, 2, 0, 5'd9);
    wait_done();
    chk_seq("R7", "SECWWD");
    chk(cap_byte == 8'hA0, "R3", "read code byte", $sformatf("%h", cap_byte), "a0");
    set_tx(8);
    issue(7'h40, 0, 3'd6, 0, 1, 1, 5'd2);
    wait_done();
    chk_seq("R5", "RCWXPD");
    chk_first("R5");
  endtask

  task automatic t_threshold();
    set_tx(2);
    issue(7'h01, 0, 3'd6, 0, 1, 1, 5'd1);
    repeat (10) @(negedge clk);
    chk(seg() == "" && busy == 1, "R4", "write held below threshold",
        seg(), "(none)");
    set_tx(5);
    wait_done();
    chk_seq("R4", "SECWXPD");
    set_rx(3);
    issue(7'h05, 1, 3'd6, 0, 1, 1, 5'd1);
    repeat (10) @(negedge clk);
    chk(seg() == "", "R4", "read held below threshold", seg(), "(none)");
    set_rx(4);
    wait_done();
    chk_seq("R4", "SECWXPD");
  endtask

  task automatic t_chain_lacking();
    set_tx(8);
    issue(7'h22, 0, 3'd6, 0, 0, 0, 5'd3);
    wait_done();
    chk_seq("R8", "SECD");
    set_tx(1);
    issue(7'h23, 0, 3'd6, 0, 1, 1, 5'd3);
    repeat (10) @(negedge clk);
    chk(seg() == "XP" && busy == 1, "R6", "closed and waiting", seg(), "XP");
    set_tx(6);
    wait_done();
    chk_seq("R6", "XPSECWXPD");
  endtask

  task automatic t_zero_len();
    set_tx(8);
    issue(7'h10, 0, 3'd6, 0, 0, 1, 5'd0);
    wait_done();
    chk_seq("R8", "SECXPD");
  endtask

  task automatic t_starve();
    tx_thresh = 8'd2;
    set_tx(2);
    issue(7'h11, 0, 3'd6, 0, 4, 1, 5'd0);
    wait_done();
    chk_seq("R9", "SECWWXPD");
    chk(cap_err == 3'd3, "R9", "underflow code", $sformatf("%0d", cap_err), "3");
    tx_thresh = 8'd4;
    set_rx(4);
    issue(7'h12, 1, 3'd6, 0, 6, 1, 5'd0);
    wait_done();
    chk_seq("R9", "SECWWWWXPD");
    chk(cap_err == 3'd4, "R9", "overflow code", $sformatf("%0d", cap_err), "4");
  endtask

  task automatic t_reject();
    set_tx(8);
    issue(7'h13, 0, 3'd3, 0, 2, 1, 5'd0);
    wait_done();
    chk_seq("R10", "D");
    chk_first("R10");
    chk(cap_err == 3'd1, "R10", "mode error", $sformatf("%0d", cap_err), "1");
    issue(7'h13, 0, 3'd6, 1, 2, 1, 5'd0);
    wait_done();
    chk_seq("R10", "D");
    chk(cap_err == 3'd2, "R10", "format error", $sformatf("%0d", cap_err), "2");
  endtask

  task automatic t_busy_ignore();
    set_tx(8);
    issue(7'h15, 0, 3'd6, 0, 3, 1, 5'd7);
    @(negedge clk);
    cmd_code = 7'h7F; cmd_speed = 3'd3; cmd_dev_idx = 5'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    chk_seq("R12", "SECWWWXPD");
    chk(done_n - dmark == 1 && cap_byte == 8'h15 && cap_idx == 5'd7, "R12",
        "command while busy ignored",
        $sformatf("n%0d %h/%0d", done_n - dmark, cap_byte, cap_idx), "n1 15/7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_cold();
    t_chain();
    t_threshold();
    t_chain_lacking();
    t_zero_len();
    t_starve();
    t_reject();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule